// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block is the exception-entry logic of a small processor core. It watches three request lines (a non-maskable request, a timer decrement request and a maskable external request) and takes one of them only when the instruction in flight has completed. Taking a request does four things in one clock edge. It copies the resume address into save register 0 and the enable and recoverable bits into save register 1. It then clears both bits and issues a one-cycle fetch redirect to that request's fixed vector.

The same block runs the return-from-interrupt operation, which puts the two machine-state bits back from save register 1 and redirects fetch to the address in save register 0. A small control-register write port lets handler code set both bits, set only the recoverable bit, or clear both at once. Through the same port it can load either save register, so that nested handlers can restore them before returning. The enable and recoverable bits and both save registers are visible as outputs.

Top module: `exc_seq`

## Requirements
- R1: A request is taken only in a cycle where `insn_done` is high; with `insn_done` low, no request is taken and no state changes because of it.
- R2: When a request is taken, `save0_o` becomes the `cur_pc` of that cycle, and `save1_o` becomes the pre-entry state with bit 1 = enable and bit 0 = recoverable.
- R3: When a request is taken, `ee_o` and `ri_o` are both 0 in the following cycle.
- R4: One cycle after a request is taken, `redirect_o` is high for that cycle and `redirect_pc_o` is `VEC_BASE` + 0x100 for the non-maskable request, + 0x900 for the decrement request and + 0x500 for the external request.
- R5: With `csr_op` = 1, both bits become 1; with `csr_op` = 2, only `ri_o` becomes 1 and `ee_o` keeps its value; with `csr_op` = 3, both bits become 0.
- R6: With `csr_op` = 4, `save0_o` is loaded from `csr_wdata`; with `csr_op` = 5, `save1_o` is loaded from `csr_wdata[1:0]`. With `csr_op` = 0, the port writes nothing.
- R7: A `ret_req` pulse redirects fetch one cycle later to the value `save0_o` held, and sets `ee_o` to the old `save1_o[1]` and `ri_o` to the old `save1_o[0]`.
- R8: While `ee_o` is 0, the external and decrement requests are ignored (no redirect, no save). The non-maskable request is taken whatever the state of `ee_o`.
- R9: When several eligible requests are present in one cycle, the non-maskable one is taken, then the decrement, then the external.
- R10: Request acceptance uses the enable value from before any same-cycle write. A return or write in the same cycle as a taken request is discarded, and a write in the same cycle as a return is discarded.
- R11: After reset, `ee_o`, `ri_o`, both save registers and `redirect_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_nmi | input | 1 | Non-maskable request, level |
| req_dec | input | 1 | Timer decrement request, level, gated by enable |
| req_ext | input | 1 | External request, level, gated by enable |
| insn_done | input | 1 | Current instruction has completed this cycle |
| cur_pc | input | AW | Address to resume at if a request is taken now |
| ret_req | input | 1 | Return-from-interrupt strobe |
| csr_op | input | 3 | Control write: 0 none, 1 set both, 2 set recoverable, 3 clear both, 4 load save 0, 5 load save 1 |
| csr_wdata | input | AW | Data for the save-register loads |
| redirect_o | output | 1 | One-cycle fetch redirect |
| redirect_pc_o | output | AW | Redirect target address |
| ee_o | output | 1 | External-enable bit |
| ri_o | output | 1 | Recoverable bit |
| save0_o | output | AW | Save register 0 (resume address) |
| save1_o | output | 2 | Save register 1 (bit 1 enable, bit 0 recoverable) |

## Verification
Request entry can land in the same cycle as a return or a control write. It can also land in the same cycle as a write that would change the enable the entry depends on. The bench provokes each pairing by strobing `ret_req` or `csr_op` together with a request and `insn_done`. It then judges the result against its own model. The model expects the entry redirect alone, save contents built from the pre-write bits, and no trace of the discarded write. A set-both write alongside a masked external request is expected to raise the enable without taking the request.

// File: rtl/exc_seq_pkg.sv
// Shared definitions for the exception sequencer: control-write opcodes,
// request-source indices in priority order, and the vector offset of each.
package exc_seq_pkg;

    typedef enum logic [2:0] {
        OP_NONE     = 3'd0,
        OP_SET_BOTH = 3'd1,
        OP_SET_RI   = 3'd2,
        OP_CLR_BOTH = 3'd3,
        OP_LD_SAVE0 = 3'd4,
        OP_LD_SAVE1 = 3'd5
    } csr_op_e;

    // Index 0 is the highest priority.
    localparam int SRC_N   = 3;
    localparam int SRC_NMI = 0;
    localparam int SRC_DEC = 1;
    localparam int SRC_EXT = 2;

    localparam int OFS_W = 12;

    // Vector offset for a source index.
    function automatic logic [OFS_W-1:0] src_offset(input int unsigned idx);
        case (idx)
            0:       return 12'h100;
            1:       return 12'h900;
            default: return 12'h500;
        endcase
    endfunction

endpackage

// File: rtl/exc_prio.sv
// Request qualifier and fixed-priority picker.
// Assumes: req[0] is the highest priority; a source is eligible only when
// the current instruction has completed and, if maskable, the enable is set.
// Purely combinational apart from the clock used by its assertions.
module exc_prio #(
    parameter int            N        = exc_seq_pkg::SRC_N,
    parameter logic [N-1:0]  MASKABLE = 3'b110,
    localparam int           IW       = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic          en,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          any,
    output logic [IW-1:0] idx
);

    logic [N-1:0] elig;

    // Qualify each source with completion and, where maskable, the enable.
    generate
        for (genvar g = 0; g < N; g++) begin : g_qual
            assign elig[g] = done & req[g] & (en | ~MASKABLE[g]);
        end
    endgenerate

    // Pick the lowest-index eligible source.
    always_comb begin
        grant = '0;
        idx   = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && !any) begin
                grant[i] = 1'b1;
                idx      = IW'(i);
                any      = 1'b1;
            end
        end
    end

    a_r9_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r9_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req[exc_seq_pkg::SRC_NMI]) |-> grant[exc_seq_pkg::SRC_NMI]);

    a_r8_ext_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !grant[exc_seq_pkg::SRC_EXT] && !grant[exc_seq_pkg::SRC_DEC]);

    a_r1_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !any);

endmodule

// File: rtl/exc_state.sv
// Machine-state bits (enable, recoverable) and the two save registers.
// Assumes: take, ret and the control op may arrive together; entry beats
// return, and return beats a control write. Entry saves pre-write bits.
module exc_state #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          ret,
    input  logic [2:0]    op,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] cur_pc,
    output logic          ee,
    output logic          ri,
    output logic [AW-1:0] save0,
    output logic [1:0]    save1
);
    import exc_seq_pkg::*;

    csr_op_e op_e;
    logic    wr_ok;

    assign op_e  = csr_op_e'(op);
    assign wr_ok = !take && !ret;

    // Update enable and recoverable bits by entry, return or control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ee <= 1'b0;
            ri <= 1'b0;
        end else if (take) begin
            ee <= 1'b0;
            ri <= 1'b0;
        end else if (ret) begin
            ee <= save1[1];
            ri <= save1[0];
        end else begin
            case (op_e)
                OP_SET_BOTH: begin ee <= 1'b1; ri <= 1'b1; end
                OP_SET_RI:   ri <= 1'b1;
                OP_CLR_BOTH: begin ee <= 1'b0; ri <= 1'b0; end
                default:     ;
            endcase
        end
    end

    // Capture resume address and state on entry, or load them by write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save0 <= '0;
            save1 <= '0;
        end else if (take) begin
            save0 <= cur_pc;
            save1 <= {ee, ri};
        end else if (wr_ok && op_e == OP_LD_SAVE0) begin
            save0 <= wdata;
        end else if (wr_ok && op_e == OP_LD_SAVE1) begin
            save1 <= wdata[1:0];
        end
    end

    a_r3_clear_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !ee && !ri);

    a_r2_save_pc: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> save0 == $past(cur_pc));

    a_r2_save_bits: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> save1 == $past({ee, ri}));

    a_r7_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !take) |=> {ee, ri} == $past(save1));

    a_r5_set_both: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && op_e == OP_SET_BOTH) |=> ee && ri);

    a_r5_set_ri_keeps_ee: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && op_e == OP_SET_RI) |=> ri && $stable(ee));

endmodule

// File: rtl/exc_redir.sv
// Registered fetch redirect: vector target on entry, save register 0 on
// return. Assumes take and ret arrive qualified (ret already loses to take).
module exc_redir #(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] VEC_BASE = '0,
    parameter int            IW       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [IW-1:0] idx,
    input  logic          ret,
    input  logic [AW-1:0] save0,
    output logic          redirect,
    output logic [AW-1:0] redirect_pc
);
    import exc_seq_pkg::*;

    logic [AW-1:0] vec_pc;

    // Vector address of the granted source.
    assign vec_pc = VEC_BASE + AW'(src_offset(int'(idx)));

    // Drive a one-cycle redirect with the chosen target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect    <= 1'b0;
            redirect_pc <= '0;
        end else begin
            redirect <= take || ret;
            if (take)
                redirect_pc <= vec_pc;
            else if (ret)
                redirect_pc <= save0;
        end
    end

    a_r7_return_target: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !take) |=> redirect && redirect_pc == $past(save0));

    a_r4_entry_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !ret) |=> !redirect);

endmodule

// File: rtl/exc_seq.sv
// Exception entry and return sequencer, top level.
// Takes one of three requests when an instruction completes, saves the
// resume address and state bits, clears the bits and redirects fetch; also
// performs the return and the control writes. Assumes level requests and
// single-cycle strobes for ret_req and csr_op.
module exc_seq #(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] VEC_BASE = 32'hFFF0_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_nmi,
    input  logic          req_dec,
    input  logic          req_ext,
    input  logic          insn_done,
    input  logic [AW-1:0] cur_pc,
    input  logic          ret_req,
    input  logic [2:0]    csr_op,
    input  logic [AW-1:0] csr_wdata,
    output logic          redirect_o,
    output logic [AW-1:0] redirect_pc_o,
    output logic          ee_o,
    output logic          ri_o,
    output logic [AW-1:0] save0_o,
    output logic [1:0]    save1_o
);
    import exc_seq_pkg::*;

    localparam int IW = (SRC_N > 1) ? $clog2(SRC_N) : 1;

    logic [SRC_N-1:0] req_vec;
    logic [SRC_N-1:0] grant;
    logic             take;
    logic             ret_go;
    logic [IW-1:0]    idx;

    // Gather request lines in priority order.
    always_comb begin
        req_vec          = '0;
        req_vec[SRC_NMI] = req_nmi;
        req_vec[SRC_DEC] = req_dec;
        req_vec[SRC_EXT] = req_ext;
    end

    assign ret_go = ret_req && !take;

    exc_prio #(
        .N        (SRC_N),
        .MASKABLE (3'b110)
    ) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (insn_done),
        .en    (ee_o),
        .req   (req_vec),
        .grant (grant),
        .any   (take),
        .idx   (idx)
    );

    exc_state #(
        .AW (AW)
    ) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (take),
        .ret    (ret_req),
        .op     (csr_op),
        .wdata  (csr_wdata),
        .cur_pc (cur_pc),
        .ee     (ee_o),
        .ri     (ri_o),
        .save0  (save0_o),
        .save1  (save1_o)
    );

    exc_redir #(
        .AW       (AW),
        .VEC_BASE (VEC_BASE),
        .IW       (IW)
    ) u_redir (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .idx         (idx),
        .ret         (ret_go),
        .save0       (save0_o),
        .redirect    (redirect_o),
        .redirect_pc (redirect_pc_o)
    );

    a_r1_entry_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_o && !$past(ret_req)) |-> $past(insn_done));

    a_r10_entry_beats_return: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ret_req) |=> !ee_o && !ri_o);

    a_r9_grant_matches_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $countones(grant) == 1);

endmodule

// File: tb/sim_exc_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies one operation, updates a model built
// from the requirements and queues any expected redirect; the monitor pops
// and compares each redirect as it appears.
module sim_exc_seq;
    localparam int          AW = 32;
    localparam logic [31:0] VB = 32'hFFF0_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_nmi = 0, req_dec = 0, req_ext = 0, insn_done = 0, ret_req = 0;
    logic [AW-1:0] cur_pc = '0, csr_wdata = '0;
    logic [2:0]    csr_op = '0;
    logic          redirect_o, ee_o, ri_o;
    logic [AW-1:0] redirect_pc_o, save0_o;
    logic [1:0]    save1_o;

    int n_chk = 0;
    int n_err = 0;
    bit done_flag = 0;

    logic [31:0] exp_q[$];
    logic        m_ee = 0, m_ri = 0;
    logic [31:0] m_s0 = '0;
    logic [1:0]  m_s1 = '0;

    always #10 clk = ~clk;

    exc_seq #(.AW(AW), .VEC_BASE(VB)) u0 (
        .clk(clk), .rst_n(rst_n), .req_nmi(req_nmi), .req_dec(req_dec),
        .req_ext(req_ext), .insn_done(insn_done), .cur_pc(cur_pc),
        .ret_req(ret_req), .csr_op(csr_op), .csr_wdata(csr_wdata),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
        .ee_o(ee_o), .ri_o(ri_o), .save0_o(save0_o), .save1_o(save1_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic chk_state(input string req);
        chk({req, " ee"}, 32'(ee_o), 32'(m_ee));
        chk({req, " ri"}, 32'(ri_o), 32'(m_ri));
        chk({req, " save0"}, save0_o, m_s0);
        chk({req, " save1"}, 32'(save1_o), 32'(m_s1));
    endtask

    // Apply one cycle of stimulus, model it, queue the expected redirect.
    task automatic drive(input logic d, input logic n, input logic e, input logic t,
                         input logic [31:0] pc, input logic [2:0] op,
                         input logic [31:0] wd, input logic r);
        logic        tk;
        logic [31:0] tgt;
        @(negedge clk);
        insn_done = d; req_nmi = n; req_ext = e; req_dec = t;
        cur_pc = pc; csr_op = op; csr_wdata = wd; ret_req = r;
        tk  = 1'b1;
        tgt = '0;
        if (d && n)             tgt = VB + 32'h100;
        else if (d && t && m_ee) tgt = VB + 32'h900;
        else if (d && e && m_ee) tgt = VB + 32'h500;
        else                    tk = 1'b0;
        @(posedge clk);
        if (tk) begin
            exp_q.push_back(tgt);
            m_s0 = pc; m_s1 = {m_ee, m_ri}; m_ee = 0; m_ri = 0;
        end else if (r) begin
            exp_q.push_back(m_s0);
            {m_ee, m_ri} = m_s1;
        end else begin
            case (op)
                3'd1: begin m_ee = 1; m_ri = 1; end
                3'd2: m_ri = 1;
                3'd3: begin m_ee = 0; m_ri = 0; end
                3'd4: m_s0 = wd;
                3'd5: m_s1 = wd[1:0];
                default: ;
            endcase
        end
        @(negedge clk);
        insn_done = 0; req_nmi = 0; req_ext = 0; req_dec = 0;
        csr_op = 0; ret_req = 0;
    endtask

    // Monitor: every redirect must match the head of the queue, and a queued
    // redirect must appear at the first negedge after its edge.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (redirect_o) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL R4/R8 unexpected redirect got=%h exp=none", redirect_pc_o);
                end else begin
                    chk("R4/R7 redirect target", redirect_pc_o, exp_q.pop_front());
                end
            end else if (exp_q.size() != 0) begin
                n_chk++; n_err++;
                $display("FAIL R4/R7 missing redirect got=none exp=%h", exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog got=timeout exp=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk("R11 redirect", 32'(redirect_o), 0);
        chk_state("R11");
        // R8: external and decrement ignored while enable is clear
        drive(1, 0, 1, 0, 32'h40, 0, 0, 0); chk_state("R8 ext masked");
        drive(1, 0, 0, 1, 32'h44, 0, 0, 0); chk_state("R8 dec masked");
        // R5: set both
        drive(0, 0, 0, 0, 0, 3'd1, 0, 0); chk_state("R5 set both");
        // R1: no completion, no entry
        drive(0, 1, 1, 1, 32'h48, 0, 0, 0); chk_state("R1 no done");
        // R2 R3 R4: external entry
        drive(1, 0, 1, 0, 32'h1234, 0, 0, 0); chk_state("R2/R3 ext entry");
        // R5: set recoverable only keeps enable at 0
        drive(0, 0, 0, 0, 0, 3'd2, 0, 0); chk_state("R5 set ri");
        drive(1, 0, 0, 1, 32'h50, 0, 0, 0); chk_state("R8 dec masked after set ri");
        // R8: non-maskable taken with enable clear, saves 01
        drive(1, 1, 0, 0, 32'h2000, 0, 0, 0); chk_state("R8 nmi unmasked");
        // R9: priority
        drive(0, 0, 0, 0, 0, 3'd1, 0, 0);
        drive(1, 1, 1, 1, 32'h3000, 0, 0, 0); chk_state("R9 nmi wins");
        drive(0, 0, 0, 0, 0, 3'd1, 0, 0);
        drive(1, 0, 1, 1, 32'h3100, 0, 0, 0); chk_state("R9 dec over ext");
        // R7: return restores 11 and jumps to 0x3100
        drive(0, 0, 0, 0, 0, 0, 0, 1); chk_state("R7 return");
        // R6: loads, then return uses them
        drive(0, 0, 0, 0, 0, 3'd4, 32'h000A_BCD0, 0); chk_state("R6 load save0");
        drive(0, 0, 0, 0, 0, 3'd5, 32'hFFFF_FFFE, 0); chk_state("R6 load save1");
        drive(0, 0, 0, 0, 0, 0, 32'h1111_1111, 0);    chk_state("R6 no-op write");
        drive(0, 0, 0, 0, 0, 0, 0, 1); chk_state("R7 return loaded");
        // R5: clear both
        drive(0, 0, 0, 0, 0, 3'd3, 0, 0); chk_state("R5 clear both");
        // R10: write beside masked request uses pre-write enable
        drive(1, 0, 1, 0, 32'h4000, 3'd1, 0, 0); chk_state("R10 pre-write enable");
        // R10: entry beside return and write; both discarded
        drive(1, 0, 1, 0, 32'h4100, 3'd4, 32'h5555_0000, 1); chk_state("R10 entry beats ret/write");
        // R10: return beside a write; write discarded
        drive(0, 0, 0, 0, 0, 3'd3, 0, 1); chk_state("R10 ret beats write");
        drive(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R10 queue drained", 32'(exp_q.size()), 0);
        finish_run();
    end
endmodule